// File: doc/BRIEF.md
# Paged Data Address Translator

This block maps a 16-bit logical data address onto a 24-bit physical address. Physical memory is split into 16 KB pages, and a bank of four page pointers holds a 10-bit page number each. The two top bits of the logical address choose one pointer. Its page number then forms the upper part of the physical address, and the remaining 14 address bits form the lower part. Because of this, two logical addresses that sit next to each other across a 16 KB line can land on pages that are far apart.

Each request can bypass the pointer bank in one of two ways. A page override puts a 10-bit page number carried with the request in place of the pointer. A segment override treats memory as 64 KB segments and places an 8-bit segment number above the full 16-bit offset. The pointers are loaded through a single-entry write port. Results come out one clock after the request, from a register, together with a valid strobe.

The output stage is a two-state machine. `ST_EMPTY` means no result is presented this cycle. `ST_ISSUE` means a translated address is presented. The machine moves from `ST_EMPTY` to `ST_ISSUE` on a request and stays in `ST_ISSUE` while requests keep arriving back to back. It returns from `ST_ISSUE` to `ST_EMPTY` on a cycle with no request. `ST_EMPTY` stays in `ST_EMPTY` while the input is quiet.

Top module: `paged_addr_xlat`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_valid` is 0 and `res_phys` is 0.
- R2: After reset, pointer k holds page k for k = 0..3, so pointer-mode translation of any logical address returns that same address zero-extended to 24 bits.
- R3: With `req_mode` = 2'b00 (pointer mode), the result is {pointer[`req_addr`[15:14]], `req_addr`[13:0]}.
- R4: `req_mode` = 2'b11 translates exactly as pointer mode.
- R5: With `req_mode` = 2'b01 (page override), the result is {`req_page`, `req_addr`[13:0]}, and the pointer contents have no effect.
- R6: With `req_mode` = 2'b10 (segment override), the result is {`req_seg`, `req_addr`[15:0]}.
- R7: `res_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. While `res_valid` is low, `res_phys` holds its last value.
- R8: A pointer write (`ptr_we`, `ptr_sel`, `ptr_page`) applies to translations requested on a later cycle. A translation requested in the same cycle as the write uses the old value.
- R9: A pointer write changes only the pointer named by `ptr_sel`.
- R10: Logical addresses 16'h3FFF and 16'h4000 are translated through pointer 0 and pointer 1 respectively, so their physical addresses follow those two pointers independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Index of the pointer to write |
| ptr_page | input | 10 | Page number to write |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical address |
| req_mode | input | 2 | 00 pointer, 01 page override, 10 segment override, 11 pointer |
| req_page | input | 10 | Page number for page override |
| req_seg | input | 8 | Segment number for segment override |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_phys | output | 24 | Translated physical address |

## Verification
If a pointer holds the wrong page, the next pointer-mode request that selects it shows a wrong upper field on `res_phys` one clock later. Corrupted pointers are therefore found by reading every pointer after each write, including the ones that were not written. If the output state machine goes wrong, `res_valid` is dropped or extra on the very next cycle. A mode decode error shows up in the first result of that mode. A write that takes effect too early shows up on a request made in the same cycle as the write.

// File: rtl/pdat_pkg.sv
package pdat_pkg;
    localparam int LOG_W  = 16;
    localparam int PAGE_W = 10;
    localparam int SEG_W  = 8;
    localparam int NPTR   = 4;

    typedef enum logic [1:0] {
        XM_PTR  = 2'b00,
        XM_PAGE = 2'b01,
        XM_SEG  = 2'b10,
        XM_ALT  = 2'b11
    } xmode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_ISSUE = 1'b1
    } ostate_e;
endpackage

// File: rtl/pdat_ptr_bank.sv
module pdat_ptr_bank #(
    parameter int NPTR   = 4,
    parameter int PAGE_W = 10,
    localparam int SEL_W = $clog2(NPTR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [PAGE_W-1:0]        wr_page,
    output logic [NPTR*PAGE_W-1:0]   pages_flat
);
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        logic [PAGE_W-1:0] page_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q <= PAGE_W'(k);
            end else if (wr_en && (wr_sel == SEL_W'(k))) begin
                page_q <= wr_page;
            end
        end
        assign pages_flat[k*PAGE_W +: PAGE_W] = page_q;
    end
endmodule

// File: rtl/pdat_xlate.sv
module pdat_xlate
    import pdat_pkg::*;
#(
    parameter int NPTR   = 4,
    parameter int LOG_W  = 16,
    parameter int PAGE_W = 10,
    parameter int SEG_W  = 8,
    localparam int SEL_W  = $clog2(NPTR),
    localparam int OFS_W  = LOG_W - SEL_W,
    localparam int PHYS_W = PAGE_W + OFS_W
) (
    input  logic [LOG_W-1:0]         addr,
    input  logic [1:0]               mode,
    input  logic [PAGE_W-1:0]        ovr_page,
    input  logic [SEG_W-1:0]         ovr_seg,
    input  logic [NPTR*PAGE_W-1:0]   pages_flat,
    output logic [PHYS_W-1:0]        phys
);
    logic [SEL_W-1:0]  sel;
    logic [PAGE_W-1:0] ptr_page;
    logic [OFS_W-1:0]  ofs;

    assign sel = addr[LOG_W-1 -: SEL_W];
    assign ofs = addr[OFS_W-1:0];

    always_comb begin
        ptr_page = '0;
        for (int k = 0; k < NPTR; k++) begin
            if (sel == SEL_W'(k)) ptr_page = pages_flat[k*PAGE_W +: PAGE_W];
        end
    end

    always_comb begin
        unique case (xmode_e'(mode))
            XM_PAGE: phys = {ovr_page, ofs};
            XM_SEG:  phys = PHYS_W'({ovr_seg, addr});
            XM_PTR,
            XM_ALT:  phys = {ptr_page, ofs};
            default: phys = {ptr_page, ofs};
        endcase
    end
endmodule

// File: rtl/pdat_out_stage.sv
module pdat_out_stage
    import pdat_pkg::*;
#(
    parameter int PHYS_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PHYS_W-1:0] in_phys,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_phys
);
    ostate_e state_q, state_d;
    logic [PHYS_W-1:0] phys_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_ISSUE;
            ST_ISSUE: if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        phys_q <= '0;
        else if (in_valid) phys_q <= in_phys;
    end

    always_comb begin
        out_valid = (state_q == ST_ISSUE);
        out_phys  = phys_q;
    end
endmodule

// File: rtl/paged_addr_xlat.sv
module paged_addr_xlat
    import pdat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_we,
    input  logic [1:0]  ptr_sel,
    input  logic [9:0]  ptr_page,
    input  logic        req_valid,
    input  logic [15:0] req_addr,
    input  logic [1:0]  req_mode,
    input  logic [9:0]  req_page,
    input  logic [7:0]  req_seg,
    output logic        res_valid,
    output logic [23:0] res_phys
);
    localparam int SEL_W  = $clog2(NPTR);
    localparam int PHYS_W = PAGE_W + LOG_W - SEL_W;

    logic [NPTR*PAGE_W-1:0] pages_flat;
    logic [PHYS_W-1:0]      phys_c;

    pdat_ptr_bank #(.NPTR(NPTR), .PAGE_W(PAGE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ptr_we),
        .wr_sel     (ptr_sel),
        .wr_page    (ptr_page),
        .pages_flat (pages_flat)
    );

    pdat_xlate #(.NPTR(NPTR), .LOG_W(LOG_W), .PAGE_W(PAGE_W), .SEG_W(SEG_W)) u_xlate (
        .addr       (req_addr),
        .mode       (req_mode),
        .ovr_page   (req_page),
        .ovr_seg    (req_seg),
        .pages_flat (pages_flat),
        .phys       (phys_c)
    );

    pdat_out_stage #(.PHYS_W(PHYS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_phys   (phys_c),
        .out_valid (res_valid),
        .out_phys  (res_phys)
    );
endmodule

// File: rtl/pdat_checker.sv
module pdat_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic [1:0]  req_mode,
    input logic [9:0]  req_page,
    input logic [7:0]  req_seg,
    input logic        res_valid,
    input logic [23:0] res_phys
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!res_valid && res_phys == 24'h0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> res_valid); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !res_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> $stable(res_phys)); // R7
    AST_PAGE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01) |=> res_phys == {$past(req_page), $past(req_addr[13:0])}); // R5
    AST_SEG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b10) |=> res_phys == {$past(req_seg), $past(req_addr)}); // R6
    AST_PTR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[0] == req_mode[1]) |=> res_phys[13:0] == $past(req_addr[13:0])); // R3
endmodule

bind paged_addr_xlat pdat_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_mode  (req_mode),
    .req_page  (req_page),
    .req_seg   (req_seg),
    .res_valid (res_valid),
    .res_phys  (res_phys)
);

// File: tb/paged_addr_xlat_test.sv
module paged_addr_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_we = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [9:0]  ptr_page = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic [9:0]  req_page = '0;
    logic [7:0]  req_seg = '0;
    logic        res_valid;
    logic [23:0] res_phys;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [23:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    logic [9:0] model[4];

    always #2 clk = ~clk;

    paged_addr_xlat uut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_page(ptr_page),
        .req_valid(req_valid), .req_addr(req_addr), .req_mode(req_mode),
        .req_page(req_page), .req_seg(req_seg), .res_valid(res_valid), .res_phys(res_phys)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_phys(logic [15:0] a, logic [1:0] m, logic [9:0] pg, logic [7:0] sg);
        case (m)
            2'b01:   return {pg, a[13:0]};
            2'b10:   return {sg, a};
            default: return {model[a[15:14]], a[13:0]};
        endcase
    endfunction

    task automatic send(input logic [15:0] a, input logic [1:0] m, input logic [9:0] pg,
                        input logic [7:0] sg, input string tag);
        item_t it;
        @(negedge clk);
        ptr_we = 1'b0;
        req_valid = 1'b1; req_addr = a; req_mode = m; req_page = pg; req_seg = sg;
        it.exp = expect_phys(a, m, pg, sg);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic write_ptr(input logic [1:0] s, input logic [9:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        ptr_we = 1'b1; ptr_sel = s; ptr_page = v;
        model[s] = v;
    endtask

    task automatic send_and_write(input logic [15:0] a, input logic [1:0] s, input logic [9:0] v, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_mode = 2'b00;
        ptr_we = 1'b1; ptr_sel = s; ptr_page = v;
        it.exp = expect_phys(a, 2'b00, '0, '0);
        it.tag = tag;
        q.push_back(it);
        model[s] = v;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; ptr_we = 1'b0;
    endtask

    // Monitor: pops one expected item per result strobe
    logic [23:0] last_phys = '0;
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            if (res_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected strobe", res_phys, 24'h0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(res_phys == it.exp, it.tag, res_phys, it.exp);
                end
            end else begin
                if (q.size() != 0) begin
                    check(1'b0, "R7 missing strobe", res_phys, q[0].exp);
                    void'(q.pop_front());
                end
                check(res_phys == last_phys, "R7 hold while idle", res_phys, last_phys);
            end
            last_phys = res_phys;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = 10'(k);
        repeat (3) @(posedge clk);
        #1;
        check(res_valid == 1'b0, "R1 valid in reset", {23'h0, res_valid}, 24'h0);
        check(res_phys == 24'h0, "R1 phys in reset", res_phys, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(res_valid == 1'b0 && res_phys == 24'h0, "R1 first cycle", res_phys, 24'h0);
        mon_en = 1'b1;

        // R2 identity after reset
        send(16'h0000, 2'b00, '0, '0, "R2 addr 0000");
        send(16'h3FFF, 2'b00, '0, '0, "R2 addr 3FFF");
        send(16'h4000, 2'b00, '0, '0, "R2 addr 4000");
        send(16'h9ABC, 2'b00, '0, '0, "R2 addr 9ABC");
        send(16'hFFFF, 2'b00, '0, '0, "R2 addr FFFF");
        idle();

        // R3 pointer mode with remapped pointers
        write_ptr(2'd0, 10'h100);
        write_ptr(2'd1, 10'h2AB);
        write_ptr(2'd2, 10'h3FF);
        write_ptr(2'd3, 10'h055);
        send(16'h1234, 2'b00, 10'h3C3, 8'h11, "R3 ptr0");
        send(16'h5678, 2'b00, 10'h3C3, 8'h11, "R3 ptr1");
        send(16'hABCD, 2'b00, 10'h3C3, 8'h11, "R3 ptr2");
        send(16'hE001, 2'b00, 10'h3C3, 8'h11, "R3 ptr3");

        // R10 boundary pair
        send(16'h3FFF, 2'b00, '0, '0, "R10 below 16K line via ptr0");
        send(16'h4000, 2'b00, '0, '0, "R10 above 16K line via ptr1");
        idle();

        // R4 alternate encoding
        send(16'h7FFE, 2'b11, 10'h001, 8'hFF, "R4 mode 11 ptr1");
        send(16'hC010, 2'b11, 10'h001, 8'hFF, "R4 mode 11 ptr3");

        // R5 page override
        send(16'h8123, 2'b01, 10'h2FF, 8'h00, "R5 page override");
        send(16'h0001, 2'b01, 10'h000, 8'hAA, "R5 page override zero");

        // R6 segment override
        send(16'hBEEF, 2'b10, 10'h155, 8'hC3, "R6 segment override");
        send(16'h0000, 2'b10, 10'h155, 8'hFF, "R6 segment top");
        idle();
        idle();

        // R9 only the selected pointer changes
        write_ptr(2'd2, 10'h0F0);
        send(16'h0010, 2'b00, '0, '0, "R9 ptr0 unchanged");
        send(16'h4010, 2'b00, '0, '0, "R9 ptr1 unchanged");
        send(16'h8010, 2'b00, '0, '0, "R9 ptr2 written");
        send(16'hC010, 2'b00, '0, '0, "R9 ptr3 unchanged");

        // R8 same-cycle write uses old value, next cycle new
        send_and_write(16'hC123, 2'd3, 10'h2C2, "R8 same cycle old value");
        send(16'hC123, 2'b00, '0, '0, "R8 next cycle new value");
        send_and_write(16'h0456, 2'd1, 10'h111, "R8 write other pointer");
        send(16'h4456, 2'b00, '0, '0, "R8 written pointer visible");
        idle();
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7 queue drained", 24'(q.size()), 24'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 24'h0, 24'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule